// File: doc/BRIEF.md
# System Control Port Register File

This block is a byte-wide register file that sits on a simple synchronous I/O bus and answers a small, fixed set of system control port addresses. A few of those ports hold live control state that drives pins of the block directly: a soft-reset request, a byte-order flag, a drive-activity indicator, a four-bit system control field and an I/O map-type select. Two ports do not store anything on write. Instead, each sends a one-cycle request to toggle the write lock of its own region of non-volatile memory.

Several ports are read-only. They return fixed identification, feature and equipment codes, and writes to them are dropped. A read of any address that is not decoded returns all ones. The bus has an address, separate write and read strobes, write data and registered read data. A write takes effect on the clock edge that samples the strobe. Read data appears on the edge that samples the read strobe and holds until the next read.

Top module: `sys_ctrl_ports`

## Requirements
- R1: After reset every control output (soft reset, byte-order flag, drive light, control field, map type, both lock pulses) is 0 and the read data is 0x00.
- R2: A write to 0x0092 sets the soft-reset output to data bit 0 and the byte-order flag to data bit 1. A read of 0x0092 returns the byte-order flag in bit 1 and zeros in every other bit.
- R3: Reads of 0x0800, 0x0802 and 0x0803 return 0xEF, 0xAD and 0xE0. Writes to these three addresses leave every output unchanged.
- R4: Reads of 0x080C, 0x0810, 0x0818 and 0x0823 return 0x3C, 0x39, 0x00 and 0x03.
- R5: A write to 0x0808 sets the drive-light output to data bit 0. Writes to any other address leave the drive light unchanged.
- R6: A write to 0x0810 raises lock-1 pulse for exactly the one cycle after the accepting edge. A write to 0x0812 does the same on lock-2 pulse. The data value is irrelevant, and no other write raises either pulse.
- R7: A write to 0x081C stores data bits 3:0 into the control field, which drives the control output. A read of 0x081C returns the field in bits 3:0 with bits 7:4 zero.
- R8: A write to 0x0850 sets the map-type output to data bit 0. A read of 0x0850 returns it in bit 0 with the other bits zero.
- R9: A read of any address not listed in R2 to R8 returns 0xFF. This includes 0x0808, 0x0812 and 0x0814. A write to 0x0814 or to any unlisted address changes no output.
- R10: Read data is registered: it takes the addressed value on the edge that samples the read strobe and holds its value in every cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Port address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| soft_rst_o | output | 1 | Soft-reset request level |
| endian_o | output | 1 | Byte-order flag |
| drive_led_o | output | 1 | Drive-activity light |
| sys_ctl_o | output | 4 | System control field |
| map_type_o | output | 1 | I/O map-type select |
| lock1_pulse_o | output | 1 | Lock-toggle request, region 1 |
| lock2_pulse_o | output | 1 | Lock-toggle request, region 2 |

## Verification
The assertions check the per-cycle rules on every cycle. Each lock pulse must be traced to a write of its own port on the previous edge, and the two pulses are never high together. Soft reset and the control field must follow the data of the write that addressed them. The drive light and map type must hold when their port is not written, read data must hold without a read strobe, and the identification and no-effect ports must return their codes. The bench's scenarios cover the rest. These are whole read-back values across the address map, the 0xFF answer for unlisted and write-only addresses, and the proof that writes to read-only or ignored ports leave all state untouched, under random address and data mixes.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_LOCKS = 2;

  localparam logic [15:0] A_SPECIAL   = 16'h0092;
  localparam logic [15:0] A_CPU_CFG   = 16'h0800;
  localparam logic [15:0] A_BASE_FEAT = 16'h0802;
  localparam logic [15:0] A_BASE_STAT = 16'h0803;
  localparam logic [15:0] A_LED       = 16'h0808;
  localparam logic [15:0] A_EQUIP     = 16'h080C;
  localparam logic [15:0] A_LOCK1     = 16'h0810;
  localparam logic [15:0] A_LOCK2     = 16'h0812;
  localparam logic [15:0] A_L2INV     = 16'h0814;
  localparam logic [15:0] A_KEYLOCK   = 16'h0818;
  localparam logic [15:0] A_CTL       = 16'h081C;
  localparam logic [15:0] A_CACHE     = 16'h0823;
  localparam logic [15:0] A_MAP       = 16'h0850;

  localparam logic [7:0] K_CPU_CFG   = 8'hEF;
  localparam logic [7:0] K_BASE_FEAT = 8'hAD;
  localparam logic [7:0] K_BASE_STAT = 8'hE0;
  localparam logic [7:0] K_EQUIP     = 8'h3C;
  localparam logic [7:0] K_EXT_FEAT  = 8'h39;
  localparam logic [7:0] K_KEYLOCK   = 8'h00;
  localparam logic [7:0] K_CACHE     = 8'h03;
  localparam logic [7:0] K_UNMAPPED  = 8'hFF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SPECIAL, SEL_CPU_CFG, SEL_BASE_FEAT, SEL_BASE_STAT,
    SEL_LED, SEL_EQUIP, SEL_LOCK1, SEL_LOCK2, SEL_L2INV, SEL_KEYLOCK,
    SEL_CTL, SEL_CACHE, SEL_MAP
  } port_sel_e;

  typedef struct packed {
    logic       soft_rst;
    logic       endian;
    logic       led;
    logic [3:0] ctl;
    logic       map;
  } ctl_state_t;

  function automatic port_sel_e lock_sel(int idx);
    return (idx == 0) ? SEL_LOCK1 : SEL_LOCK2;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output port_sel_e         sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == ADDR_W'(A_SPECIAL))   sel_o = SEL_SPECIAL;
    else if (addr_i == ADDR_W'(A_CPU_CFG))   sel_o = SEL_CPU_CFG;
    else if (addr_i == ADDR_W'(A_BASE_FEAT)) sel_o = SEL_BASE_FEAT;
    else if (addr_i == ADDR_W'(A_BASE_STAT)) sel_o = SEL_BASE_STAT;
    else if (addr_i == ADDR_W'(A_LED))       sel_o = SEL_LED;
    else if (addr_i == ADDR_W'(A_EQUIP))     sel_o = SEL_EQUIP;
    else if (addr_i == ADDR_W'(A_LOCK1))     sel_o = SEL_LOCK1;
    else if (addr_i == ADDR_W'(A_LOCK2))     sel_o = SEL_LOCK2;
    else if (addr_i == ADDR_W'(A_L2INV))     sel_o = SEL_L2INV;
    else if (addr_i == ADDR_W'(A_KEYLOCK))   sel_o = SEL_KEYLOCK;
    else if (addr_i == ADDR_W'(A_CTL))       sel_o = SEL_CTL;
    else if (addr_i == ADDR_W'(A_CACHE))     sel_o = SEL_CACHE;
    else if (addr_i == ADDR_W'(A_MAP))       sel_o = SEL_MAP;
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  port_sel_e            sel_i,
  input  logic [3:0]           wdata_lo_i,
  output ctl_state_t           state_o,
  output logic [NUM_LOCKS-1:0] lock_pulse_o
);
  ctl_state_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
    end else if (wr_i) begin
      unique case (sel_i)
        SEL_SPECIAL: begin
          state_q.soft_rst <= wdata_lo_i[0];
          state_q.endian   <= wdata_lo_i[1];
        end
        SEL_LED: state_q.led <= wdata_lo_i[0];
        SEL_CTL: state_q.ctl <= wdata_lo_i;
        SEL_MAP: state_q.map <= wdata_lo_i[0];
        default: ;
      endcase
    end
  end

  // one register per lock region; high for the cycle after the accepting edge
  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    logic pulse_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_q <= 1'b0;
      else         pulse_q <= wr_i && (sel_i == lock_sel(g));
    end
    assign lock_pulse_o[g] = pulse_q;
  end

  assign state_o = state_q;
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  port_sel_e         sel_i,
  input  ctl_state_t        state_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    unique case (sel_i)
      SEL_SPECIAL:   rd_val = {6'b0, state_i.endian, 1'b0};
      SEL_CPU_CFG:   rd_val = K_CPU_CFG;
      SEL_BASE_FEAT: rd_val = K_BASE_FEAT;
      SEL_BASE_STAT: rd_val = K_BASE_STAT;
      SEL_EQUIP:     rd_val = K_EQUIP;
      SEL_LOCK1:     rd_val = K_EXT_FEAT;
      SEL_KEYLOCK:   rd_val = K_KEYLOCK;
      SEL_CTL:       rd_val = {4'b0, state_i.ctl};
      SEL_CACHE:     rd_val = K_CACHE;
      SEL_MAP:       rd_val = {7'b0, state_i.map};
      default:       rd_val = K_UNMAPPED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sys_ctrl_ports.sv
module sys_ctrl_ports
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              soft_rst_o,
  output logic              endian_o,
  output logic              drive_led_o,
  output logic [3:0]        sys_ctl_o,
  output logic              map_type_o,
  output logic              lock1_pulse_o,
  output logic              lock2_pulse_o
);
  port_sel_e            sel;
  ctl_state_t           state;
  logic [NUM_LOCKS-1:0] lock_pulse;
  logic                 unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[7:4];

  sysctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  sysctl_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .sel_i        (sel),
    .wdata_lo_i   (wdata_i[3:0]),
    .state_o      (state),
    .lock_pulse_o (lock_pulse)
  );

  sysctl_rdmux u_rdmux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .sel_i   (sel),
    .state_i (state),
    .rdata_o (rdata_o)
  );

  assign soft_rst_o    = state.soft_rst;
  assign endian_o      = state.endian;
  assign drive_led_o   = state.led;
  assign sys_ctl_o     = state.ctl;
  assign map_type_o    = state.map;
  assign lock1_pulse_o = lock_pulse[0];
  assign lock2_pulse_o = lock_pulse[1];
endmodule

// File: rtl/sysctl_ports_chk.sv
module sysctl_ports_chk
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              soft_rst_o,
  input logic              endian_o,
  input logic              drive_led_o,
  input logic [3:0]        sys_ctl_o,
  input logic              map_type_o,
  input logic              lock1_pulse_o,
  input logic              lock2_pulse_o
);
  assert_lock1_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock1_pulse_o |-> $past(wr_i && addr_i == ADDR_W'(A_LOCK1)));
  assert_lock2_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock2_pulse_o |-> $past(wr_i && addr_i == ADDR_W'(A_LOCK2)));
  assert_lock_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lock1_pulse_o && lock2_pulse_o));
  assert_soft_rst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(A_SPECIAL)) |=> soft_rst_o == $past(wdata_i[0]));
  assert_ctl_field_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(A_CTL)) |=> sys_ctl_o == $past(wdata_i[3:0]));
  assert_led_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADDR_W'(A_LED)) |=> $stable(drive_led_o));
  assert_map_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADDR_W'(A_MAP)) |=> $stable(map_type_o));
  assert_cpu_id_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(A_CPU_CFG)) |=> rdata_o == K_CPU_CFG);
  assert_l2inv_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(A_L2INV)) |=> rdata_o == 8'hFF);
  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind sys_ctrl_ports sysctl_ports_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sys_ctrl_ports_tb.sv
`timescale 1ns/1ps
module sys_ctrl_ports_tb;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr = 1'b0;
  logic              rd = 1'b0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              soft_rst, endian, led, map_type, lock1, lock2;
  logic [3:0]        ctl;

  int errors = 0;
  int checks = 0;

  logic       m_soft = 0, m_endian = 0, m_led = 0, m_map = 0;
  logic [3:0] m_ctl = 0;

  always #2 clk = ~clk;

  sys_ctrl_ports #(.ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .soft_rst_o(soft_rst), .endian_o(endian),
    .drive_led_o(led), .sys_ctl_o(ctl), .map_type_o(map_type),
    .lock1_pulse_o(lock1), .lock2_pulse_o(lock2)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    case (a)
      16'h0092: return {6'b0, m_endian, 1'b0};
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h3C;
      16'h0810: return 8'h39;
      16'h0818: return 8'h00;
      16'h081C: return {4'b0, m_ctl};
      16'h0823: return 8'h03;
      16'h0850: return {7'b0, m_map};
      default:  return 8'hFF;
    endcase
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    case (a)
      16'h0092: begin m_soft = d[0]; m_endian = d[1]; end
      16'h0808: m_led = d[0];
      16'h081C: m_ctl = d[3:0];
      16'h0850: m_map = d[0];
      default: ;
    endcase
  endtask

  task automatic check_state(input string tag);
    chk({tag, " R2 soft_rst"}, {7'b0, soft_rst}, {7'b0, m_soft});
    chk({tag, " R2 endian"}, {7'b0, endian}, {7'b0, m_endian});
    chk({tag, " R5 led"}, {7'b0, led}, {7'b0, m_led});
    chk({tag, " R7 ctl"}, {4'b0, ctl}, {4'b0, m_ctl});
    chk({tag, " R8 map"}, {7'b0, map_type}, {7'b0, m_map});
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    model_write(a, d);
    chk("R6 lock1 pulse", {7'b0, lock1}, {7'b0, a == 16'h0810});
    chk("R6 lock2 pulse", {7'b0, lock2}, {7'b0, a == 16'h0812});
    check_state("R9 write");
    @(negedge clk);
    chk("R6 lock1 single", {7'b0, lock1}, 8'h00);
    chk("R6 lock2 single", {7'b0, lock2}, 8'h00);
  endtask

  task automatic do_read(input logic [15:0] a, input string req);
    logic [7:0] held;
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(req, rdata, exp_read(a));
    held = rdata;
    addr = 16'h0800;
    @(negedge clk);
    chk("R10 rdata hold", rdata, held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] pool [13];
    pool = '{16'h0092, 16'h0800, 16'h0802, 16'h0803, 16'h0808, 16'h080C,
             16'h0810, 16'h0812, 16'h0814, 16'h0818, 16'h081C, 16'h0823, 16'h0850};
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 lock1", {7'b0, lock1}, 8'h00);
    chk("R1 lock2", {7'b0, lock2}, 8'h00);
    check_state("R1");
    rst_ni = 1'b1;

    // directed corners
    do_write(16'h0092, 8'h03);
    do_read(16'h0092, "R2 special read");
    do_write(16'h0092, 8'hFE);
    do_read(16'h0092, "R2 special read");
    do_write(16'h0800, 8'h00); do_write(16'h0802, 8'hFF); do_write(16'h0803, 8'h55);
    do_read(16'h0800, "R3 cpu id");
    do_read(16'h0802, "R3 feature id");
    do_read(16'h0803, "R3 status id");
    do_read(16'h080C, "R4 equipment");
    do_read(16'h0810, "R4 ext feature");
    do_read(16'h0818, "R4 keylock");
    do_read(16'h0823, "R4 cache");
    do_write(16'h0808, 8'h01);
    do_write(16'h0808, 8'hFE);
    do_write(16'h0808, 8'h81);
    do_write(16'h0810, 8'h00);
    do_write(16'h0812, 8'hA7);
    do_write(16'h081C, 8'hF5);
    do_read(16'h081C, "R7 ctl read");
    do_write(16'h0850, 8'hFF);
    do_read(16'h0850, "R8 map read");
    do_write(16'h0814, 8'hFF);
    do_write(16'h1234, 8'hFF);
    do_read(16'h0808, "R9 led addr read");
    do_read(16'h0812, "R9 lock2 addr read");
    do_read(16'h0814, "R9 l2 read");
    do_read(16'h0FFF, "R9 unmapped read");

    // simultaneous read and write: read returns prior value
    @(negedge clk);
    addr = 16'h081C; wdata = 8'h0A; wr = 1'b1; rd = 1'b1;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    chk("R10 read before write", rdata, {4'b0, m_ctl});
    model_write(16'h081C, 8'h0A);
    check_state("R7 rw");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      if ($urandom_range(3) == 0) a = 16'($urandom_range(16'h0FFF));
      else a = pool[$urandom_range(12)];
      d = 8'($urandom);
      if ($urandom_range(1) == 0) do_write(a, d);
      else do_read(a, "R9 random read");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule